// File: doc/BRIEF.md
# Ring-Qualified Translation Lookaside Buffer

This block translates 32-bit virtual addresses into physical addresses. It searches several ways of translation entries at once. Four ways hold 4 KB pages. A fifth way holds large pages whose size comes from a configuration field. Each entry stores a page number, a physical page number, an 8-bit address-space identifier and a 4-bit attribute. An entry only takes part in a match if its identifier appears in the ring register. That register holds one 8-bit identifier for each of the four protection rings, and the position where the identifier is found gives the ring of the access.

A request carries an address, an access kind and the current privilege ring. One cycle later the block returns either a translated address, or a cause code that tells a miss, a multiple hit, a privilege violation or a denied access apart. The hitting way and its ring are reported as well, which lets the same port serve as a probe. Entries are loaded through a write port and retired through an invalidate port. Some large-way entries are fixed at reset and cannot be changed.

Top module: `ring_tlb`

## Requirements
- R1: After reset, rsp_valid is 0 and the ring register holds 0x04030201. Large-way entry 3 is fixed: with size field 0 it maps 0x00300000-0x003FFFFF to the same physical range, at ring 0, with attribute 3.
- R2: A ring-register write stores rasid_wdata with its low byte forced to 0x01. Byte i holds the identifier of ring i.
- R3: An entry hits when its stored page equals the masked address and its identifier is nonzero and present in the ring register. The reported ring is the lowest byte index that holds that identifier. An identifier held in no byte gives no hit.
- R4: The response appears one cycle after req_valid. Success gives rsp_ok=1 and cause 0. No hit gives cause 16 for a fetch and 24 for a data access. Two or more hits give cause 17 for a fetch and 25 for a data access. Miss and multi-hit report way 0 and ring 0, and on any failure rsp_paddr is 0.
- R5: Ways 0-3 each hold 4 entries. They are indexed by vaddr[13:12], compare vaddr[31:12], and pass vaddr[11:0] through.
- R6: Way 4 uses the size field sz, loaded from cfg_wdata[1:0] while cfg_we is high (reset value 0). Its mask is 0xFFF00000 shifted left by 2*sz, and its 2-bit index starts at bit 20+2*sz.
- R7: If the hit ring is lower than req_priv, the cause is 18 for a fetch and 26 for a data access. This check comes before the rights check.
- R8: req_kind encodes 0 as load, 1 as store, and 2 or 3 as fetch. Attribute values below 12 grant read, and bit 0 adds execute while bit 1 adds write. Attribute 13 grants read and write. All other values grant nothing. A fetch needs execute, a load needs read and a store needs write. A denied access gives cause 20 for a fetch, 28 for a load and 29 for a store.
- R9: A write to way w stores (wr_vaddr & mask) and (wr_pte & mask). Its identifier is the ring-register byte selected by wr_pte[5:4] at write time, and its attribute is wr_pte[3:0]. A translation returns the stored physical page ORed with the unmasked address bits.
- R10: An invalidate clears the selected entry's identifier, so the entry then misses. Writes and invalidates aimed at fixed entries change nothing. A write to the same entry in the same cycle overrides an invalidate.
- R11: The response reports the hitting way on rsp_way and its ring on rsp_ring, also when the access then fails the privilege or rights check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Lookup request |
| req_vaddr | input | 32 | Address to translate |
| req_kind | input | 2 | Access kind: 0 load, 1 store, 2/3 fetch |
| req_priv | input | 2 | Current privilege ring |
| wr_en | input | 1 | Entry write strobe |
| wr_way | input | 3 | Way written |
| wr_vaddr | input | 32 | Page and index of the written entry |
| wr_pte | input | 32 | Physical page, ring select [5:4], attribute [3:0] |
| inv_en | input | 1 | Invalidate strobe |
| inv_way | input | 3 | Way invalidated |
| inv_vaddr | input | 32 | Address selecting the invalidated entry |
| rasid_we | input | 1 | Ring register write strobe |
| rasid_wdata | input | 32 | Ring register write value |
| cfg_we | input | 1 | Large-page size write strobe |
| cfg_wdata | input | 2 | Large-page size field |
| rsp_valid | output | 1 | Response valid |
| rsp_ok | output | 1 | Translation succeeded |
| rsp_cause | output | 6 | Cause code, 0 on success |
| rsp_paddr | output | 32 | Physical address |
| rsp_way | output | 3 | Hitting way |
| rsp_ring | output | 2 | Ring of the hit |

## Verification
A corrupted stored entry, ring byte or size field shows up at the ports on the first lookup that indexes it, one cycle after the request. It can appear as a wrong physical address, a spurious miss or multi-hit, or a wrong ring. A fault in the cause priority, for example rights checked before privilege, only shows when an access is both below its ring and lacking rights. The bench therefore keeps entries at several rings, with attributes that deny each access kind, and revisits them after ring-register changes.

// File: rtl/tlb_pkg.sv
// Shared types and decode helpers for the ring-qualified TLB.
// Assumes 32-bit virtual and physical addresses and four rings.
package tlb_pkg;

    typedef struct packed {
        logic [31:0] vpn;
        logic [31:0] ppn;
        logic [7:0]  asid;
        logic [3:0]  attr;
    } tlb_entry_t;

    typedef enum logic [5:0] {
        CAUSE_NONE      = 6'd0,
        CAUSE_I_MISS    = 6'd16,
        CAUSE_I_MULTI   = 6'd17,
        CAUSE_I_PRIV    = 6'd18,
        CAUSE_I_DENY    = 6'd20,
        CAUSE_D_MISS    = 6'd24,
        CAUSE_D_MULTI   = 6'd25,
        CAUSE_D_PRIV    = 6'd26,
        CAUSE_LD_DENY   = 6'd28,
        CAUSE_ST_DENY   = 6'd29
    } cause_e;

    // Rights of an attribute as {read, write, execute}.
    function automatic logic [2:0] attr_rights(input logic [3:0] attr);
        logic [2:0] r;
        r = 3'b000;
        if (attr < 4'd12)
            r = {1'b1, attr[1], attr[0]};
        else if (attr == 4'd13)
            r = 3'b110;
        return r;
    endfunction

    // Ring of an identifier as {found, ring}; the lowest matching byte wins.
    function automatic logic [2:0] asid_ring(input logic [7:0] asid, input logic [31:0] rasid);
        logic [2:0] r;
        r = 3'b000;
        for (int i = 3; i >= 0; i--)
            if (asid != 8'h00 && rasid[8*i +: 8] == asid)
                r = {1'b1, 2'(i)};
        return r;
    endfunction

endpackage

// File: rtl/tlb_ring_reg.sv
// Ring identifier register: one identifier per ring, ring i in byte i.
// Assumes software writes arrive as whole words; byte 0 is always forced to 0x01.
module tlb_ring_reg (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        we,
    input  logic [31:0] wdata,
    output logic [31:0] rasid
);

    // Holds the four ring identifiers.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rasid <= 32'h0403_0201;
        else if (we)
            rasid <= {wdata[31:8], 8'h01};
    end

    // R2
    rasid_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> rasid == {$past(wdata[31:8]), 8'h01});

    // R2
    rasid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(rasid));

endmodule

// File: rtl/tlb_way.sv
// One way of translation entries: direct-indexed storage, write and
// invalidate, and a combinational lookup of the indexed entry.
// Assumes LARGE selects the variable large-page variant driven by sz;
// entries flagged in FIXED keep their reset mapping for ever.
module tlb_way
    import tlb_pkg::*;
#(
    parameter int          IDX_W = 2,
    parameter bit          LARGE = 1'b0,
    parameter logic [63:0] FIXED = 64'd0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  sz,
    input  logic [31:0] rasid,
    input  logic        wr_en,
    input  logic [31:0] wr_vaddr,
    input  logic [31:0] wr_pte,
    input  logic        inv_en,
    input  logic [31:0] inv_vaddr,
    input  logic [31:0] lk_vaddr,
    output logic        lk_hit,
    output logic [1:0]  lk_ring,
    output logic [31:0] lk_paddr,
    output logic [3:0]  lk_attr
);

    localparam int N          = 1 << IDX_W;
    localparam int BASE_SHIFT = LARGE ? 20 : 12;

    tlb_entry_t        ent [N];
    logic [31:0]       mask;
    logic [4:0]        shamt;
    logic [IDX_W-1:0]  wr_idx, inv_idx, lk_idx;
    logic [7:0]        wr_asid;
    tlb_entry_t        sel;
    logic [2:0]        ring_f;

    // Page mask and index position for this variant.
    always_comb begin
        mask  = LARGE ? (32'hFFF0_0000 << {sz, 1'b0}) : 32'hFFFF_F000;
        shamt = LARGE ? (5'd20 + {2'b00, sz, 1'b0}) : 5'd12;
    end

    // Entry indices of the three address inputs.
    always_comb begin
        wr_idx  = IDX_W'(wr_vaddr >> shamt);
        inv_idx = IDX_W'(inv_vaddr >> shamt);
        lk_idx  = IDX_W'(lk_vaddr >> shamt);
        wr_asid = 8'(rasid >> {wr_pte[5:4], 3'b000});
    end

    // Entry storage: reset, write, invalidate; fixed entries never change.
    always_ff @(posedge clk) begin
        for (int e = 0; e < N; e++) begin
            if (!rst_n) begin
                if (FIXED[e]) begin
                    ent[e].vpn  <= 32'(e) << BASE_SHIFT;
                    ent[e].ppn  <= 32'(e) << BASE_SHIFT;
                    ent[e].asid <= 8'h01;
                    ent[e].attr <= 4'h3;
                end else begin
                    ent[e] <= '0;
                end
            end else if (!FIXED[e]) begin
                if (wr_en && int'(wr_idx) == e) begin
                    ent[e].vpn  <= wr_vaddr & mask;
                    ent[e].ppn  <= wr_pte & mask;
                    ent[e].asid <= wr_asid;
                    ent[e].attr <= wr_pte[3:0];
                end else if (inv_en && int'(inv_idx) == e) begin
                    ent[e].asid <= 8'h00;
                end
            end
        end
    end

    // Compare the indexed entry and qualify it by the ring register.
    always_comb begin
        sel      = ent[lk_idx];
        ring_f   = asid_ring(sel.asid, rasid);
        lk_hit   = (sel.vpn == (lk_vaddr & mask)) && (sel.asid != 8'h00) && ring_f[2];
        lk_ring  = ring_f[1:0];
        lk_paddr = sel.ppn | (lk_vaddr & ~mask);
        lk_attr  = sel.attr;
    end

    // R10
    inv_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_en && !(wr_en && wr_idx == inv_idx) && !FIXED[inv_idx])
        |=> ent[$past(inv_idx)].asid == 8'h00);

    // R10
    fixed_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && FIXED[wr_idx]) |=> ent[$past(wr_idx)] == $past(ent[wr_idx]));

endmodule

// File: rtl/tlb_resolve.sv
// Combines per-way hits into one response: hit counting, privilege and
// rights checks, cause selection, then a single output register.
// Assumes at most one way is meant to hit; more is reported as an error.
module tlb_resolve
    import tlb_pkg::*;
#(
    parameter int NW    = 5,
    parameter int WAY_W = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic [1:0]            req_kind,
    input  logic [1:0]            req_priv,
    input  logic [NW-1:0]         hit,
    input  logic [NW-1:0][1:0]    ring_v,
    input  logic [NW-1:0][31:0]   paddr_v,
    input  logic [NW-1:0][3:0]    attr_v,
    output logic                  rsp_valid,
    output logic                  rsp_ok,
    output logic [5:0]            rsp_cause,
    output logic [31:0]           rsp_paddr,
    output logic [WAY_W-1:0]      rsp_way,
    output logic [1:0]            rsp_ring
);

    logic [WAY_W-1:0] sel;
    logic             is_fetch, is_store, granted;
    logic [2:0]       rights;
    cause_e           cause_n;
    logic [WAY_W-1:0] way_n;
    logic [1:0]       ring_n;
    logic [31:0]      paddr_n;

    // Pick the lowest hitting way and judge the access against it.
    always_comb begin
        sel = '0;
        for (int w = NW - 1; w >= 0; w--)
            if (hit[w]) sel = WAY_W'(w);
        is_fetch = req_kind[1];
        is_store = ~req_kind[1] & req_kind[0];
        rights   = attr_rights(attr_v[sel]);
        granted  = is_fetch ? rights[0] : (is_store ? rights[1] : rights[2]);
        way_n    = '0;
        ring_n   = '0;
        paddr_n  = '0;
        if ($countones(hit) == 0) begin
            cause_n = is_fetch ? CAUSE_I_MISS : CAUSE_D_MISS;
        end else if ($countones(hit) > 1) begin
            cause_n = is_fetch ? CAUSE_I_MULTI : CAUSE_D_MULTI;
        end else begin
            way_n  = sel;
            ring_n = ring_v[sel];
            if (ring_v[sel] < req_priv)
                cause_n = is_fetch ? CAUSE_I_PRIV : CAUSE_D_PRIV;
            else if (!granted)
                cause_n = is_fetch ? CAUSE_I_DENY : (is_store ? CAUSE_ST_DENY : CAUSE_LD_DENY);
            else begin
                cause_n = CAUSE_NONE;
                paddr_n = paddr_v[sel];
            end
        end
    end

    // Response register: one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_ok    <= 1'b0;
            rsp_cause <= '0;
            rsp_paddr <= '0;
            rsp_way   <= '0;
            rsp_ring  <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_ok    <= req_valid && (cause_n == CAUSE_NONE);
            rsp_cause <= req_valid ? cause_n : CAUSE_NONE;
            rsp_paddr <= req_valid ? paddr_n : '0;
            rsp_way   <= req_valid ? way_n : '0;
            rsp_ring  <= req_valid ? ring_n : '0;
        end
    end

    // R4
    rsp_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R4
    rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R4
    multi_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && $countones(hit) > 1)
        |=> (!rsp_ok && (rsp_cause == 6'd17 || rsp_cause == 6'd25)));

    // R4
    miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && hit == '0) |=> (!rsp_ok && rsp_paddr == 32'd0));

    // R7
    priv_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (!rsp_ok || rsp_ring >= $past(req_priv)));

endmodule

// File: rtl/ring_tlb.sv
// Top of the ring-qualified TLB: small-page ways, one large-page way,
// the ring register, the large-page size field and the response stage.
// Assumes the large way is numbered directly after the small ways.
module ring_tlb
    import tlb_pkg::*;
#(
    parameter int          SMALL_WAYS  = 4,
    parameter int          SMALL_IDX_W = 2,
    parameter int          LARGE_IDX_W = 2,
    parameter logic [63:0] LARGE_FIXED = 64'h8,
    parameter int          NW          = SMALL_WAYS + 1,
    parameter int          WAY_W       = $clog2(NW)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [31:0]       req_vaddr,
    input  logic [1:0]        req_kind,
    input  logic [1:0]        req_priv,
    input  logic              wr_en,
    input  logic [WAY_W-1:0]  wr_way,
    input  logic [31:0]       wr_vaddr,
    input  logic [31:0]       wr_pte,
    input  logic              inv_en,
    input  logic [WAY_W-1:0]  inv_way,
    input  logic [31:0]       inv_vaddr,
    input  logic              rasid_we,
    input  logic [31:0]       rasid_wdata,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_wdata,
    output logic              rsp_valid,
    output logic              rsp_ok,
    output logic [5:0]        rsp_cause,
    output logic [31:0]       rsp_paddr,
    output logic [WAY_W-1:0]  rsp_way,
    output logic [1:0]        rsp_ring
);

    logic [31:0]          rasid;
    logic [1:0]           sz;
    logic [NW-1:0]        hit;
    logic [NW-1:0][1:0]   ring_v;
    logic [NW-1:0][31:0]  paddr_v;
    logic [NW-1:0][3:0]   attr_v;

    // Large-page size field.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sz <= 2'd0;
        else if (cfg_we)
            sz <= cfg_wdata;
    end

    tlb_ring_reg u_ring (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (rasid_we),
        .wdata (rasid_wdata),
        .rasid (rasid)
    );

    for (genvar w = 0; w < NW; w++) begin : g_way
        localparam bit IS_LARGE = (w == SMALL_WAYS);
        tlb_way #(
            .IDX_W (IS_LARGE ? LARGE_IDX_W : SMALL_IDX_W),
            .LARGE (IS_LARGE),
            .FIXED (IS_LARGE ? LARGE_FIXED : 64'd0)
        ) u_way (
            .clk       (clk),
            .rst_n     (rst_n),
            .sz        (sz),
            .rasid     (rasid),
            .wr_en     (wr_en && wr_way == WAY_W'(w)),
            .wr_vaddr  (wr_vaddr),
            .wr_pte    (wr_pte),
            .inv_en    (inv_en && inv_way == WAY_W'(w)),
            .inv_vaddr (inv_vaddr),
            .lk_vaddr  (req_vaddr),
            .lk_hit    (hit[w]),
            .lk_ring   (ring_v[w]),
            .lk_paddr  (paddr_v[w]),
            .lk_attr   (attr_v[w])
        );
    end

    tlb_resolve #(
        .NW    (NW),
        .WAY_W (WAY_W)
    ) u_resolve (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_kind  (req_kind),
        .req_priv  (req_priv),
        .hit       (hit),
        .ring_v    (ring_v),
        .paddr_v   (paddr_v),
        .attr_v    (attr_v),
        .rsp_valid (rsp_valid),
        .rsp_ok    (rsp_ok),
        .rsp_cause (rsp_cause),
        .rsp_paddr (rsp_paddr),
        .rsp_way   (rsp_way),
        .rsp_ring  (rsp_ring)
    );

endmodule

// File: tb/ring_tlb_bench.sv
`timescale 1ns/1ps
module ring_tlb_bench;

    typedef struct {
        logic        ok;
        logic [5:0]  cause;
        logic [31:0] paddr;
        logic [2:0]  way;
        logic [1:0]  ring;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 0; logic [31:0] req_vaddr = 0; logic [1:0] req_kind = 0, req_priv = 0;
    logic wr_en = 0; logic [2:0] wr_way = 0; logic [31:0] wr_vaddr = 0, wr_pte = 0;
    logic inv_en = 0; logic [2:0] inv_way = 0; logic [31:0] inv_vaddr = 0;
    logic rasid_we = 0; logic [31:0] rasid_wdata = 0;
    logic cfg_we = 0; logic [1:0] cfg_wdata = 0;
    logic rsp_valid, rsp_ok; logic [5:0] rsp_cause; logic [31:0] rsp_paddr;
    logic [2:0] rsp_way; logic [1:0] rsp_ring;

    int checks = 0;
    int errors = 0;

    // Reference state, built from the requirements.
    logic [31:0] m_vpn  [5][4];
    logic [31:0] m_ppn  [5][4];
    logic [7:0]  m_asid [5][4];
    logic [3:0]  m_attr [5][4];
    logic [31:0] m_rasid;
    logic [1:0]  m_sz;

    always #2.5 clk = ~clk;

    ring_tlb u_ring_tlb (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .req_kind(req_kind), .req_priv(req_priv), .wr_en(wr_en), .wr_way(wr_way),
        .wr_vaddr(wr_vaddr), .wr_pte(wr_pte), .inv_en(inv_en), .inv_way(inv_way),
        .inv_vaddr(inv_vaddr), .rasid_we(rasid_we), .rasid_wdata(rasid_wdata),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .rsp_valid(rsp_valid), .rsp_ok(rsp_ok),
        .rsp_cause(rsp_cause), .rsp_paddr(rsp_paddr), .rsp_way(rsp_way), .rsp_ring(rsp_ring)
    );

    function automatic logic [31:0] m_mask(int w);
        return (w == 4) ? (32'hFFF0_0000 << (2 * m_sz)) : 32'hFFFF_F000;
    endfunction

    function automatic int m_idx(int w, logic [31:0] v);
        return (w == 4) ? int'((v >> (20 + 2 * m_sz)) & 32'd3) : int'((v >> 12) & 32'd3);
    endfunction

    function automatic int ring_find(logic [7:0] a);
        for (int i = 0; i < 4; i++)
            if (a != 0 && m_rasid[8*i +: 8] == a) return i;
        return -1;
    endfunction

    function automatic exp_t model_look(logic [31:0] v, logic [1:0] kind, logic [1:0] priv);
        exp_t e;
        int n = 0, hw = 0, hr = 0;
        logic fetch, store, r, wr, x;
        logic [3:0] a;
        e = '{ok: 1'b0, cause: 6'd0, paddr: 32'd0, way: 3'd0, ring: 2'd0};
        for (int w = 0; w < 5; w++) begin
            int i = m_idx(w, v);
            int rg = ring_find(m_asid[w][i]);
            if (m_vpn[w][i] == (v & m_mask(w)) && m_asid[w][i] != 0 && rg >= 0) begin
                if (n == 0) begin hw = w; hr = rg; end
                n++;
            end
        end
        fetch = kind[1];
        store = !kind[1] && kind[0];
        if (n == 0) e.cause = fetch ? 6'd16 : 6'd24;
        else if (n > 1) e.cause = fetch ? 6'd17 : 6'd25;
        else begin
            e.way = 3'(hw);
            e.ring = 2'(hr);
            a = m_attr[hw][m_idx(hw, v)];
            r = (a < 12) || (a == 13);
            wr = (a < 12 && a[1]) || (a == 13);
            x = (a < 12) && a[0];
            if (hr < int'(priv)) e.cause = fetch ? 6'd18 : 6'd26;
            else if (!(fetch ? x : (store ? wr : r)))
                e.cause = fetch ? 6'd20 : (store ? 6'd29 : 6'd28);
            else begin
                e.ok = 1'b1;
                e.paddr = m_ppn[hw][m_idx(hw, v)] | (v & ~m_mask(hw));
            end
        end
        return e;
    endfunction

    task automatic model_reset();
        for (int w = 0; w < 5; w++)
            for (int i = 0; i < 4; i++) begin
                m_vpn[w][i] = 0; m_ppn[w][i] = 0; m_asid[w][i] = 0; m_attr[w][i] = 0;
            end
        m_vpn[4][3] = 32'h0030_0000; m_ppn[4][3] = 32'h0030_0000;
        m_asid[4][3] = 8'h01; m_attr[4][3] = 4'h3;
        m_rasid = 32'h0403_0201;
        m_sz = 2'd0;
    endtask

    // Apply this cycle's writes to the reference state, in the order the block sees them.
    task automatic model_update();
        if (inv_en && inv_way < 5) begin
            int i = m_idx(int'(inv_way), inv_vaddr);
            if (!(inv_way == 4 && i == 3)) m_asid[inv_way][i] = 8'h00;
        end
        if (wr_en && wr_way < 5) begin
            int i = m_idx(int'(wr_way), wr_vaddr);
            if (!(wr_way == 4 && i == 3)) begin
                m_vpn[wr_way][i]  = wr_vaddr & m_mask(int'(wr_way));
                m_ppn[wr_way][i]  = wr_pte & m_mask(int'(wr_way));
                m_asid[wr_way][i] = 8'(m_rasid >> (8 * wr_pte[5:4]));
                m_attr[wr_way][i] = wr_pte[3:0];
            end
        end
        if (rasid_we) m_rasid = {rasid_wdata[31:8], 8'h01};
        if (cfg_we) m_sz = cfg_wdata;
    endtask

    task automatic compare(exp_t e, string tag);
        checks++;
        if (rsp_valid !== 1'b1 || rsp_ok !== e.ok || rsp_cause !== e.cause ||
            rsp_paddr !== e.paddr || rsp_way !== e.way || rsp_ring !== e.ring) begin
            errors++;
            $display("FAIL %s: got v=%0d ok=%0d cause=%0d pa=%h way=%0d ring=%0d exp ok=%0d cause=%0d pa=%h way=%0d ring=%0d",
                     tag, rsp_valid, rsp_ok, rsp_cause, rsp_paddr, rsp_way, rsp_ring,
                     e.ok, e.cause, e.paddr, e.way, e.ring);
        end
    endtask

    // One cycle: predict from the pre-edge state, update the model, sample after the edge.
    task automatic tick(string tag);
        exp_t e;
        logic chk;
        chk = req_valid;
        if (chk) e = model_look(req_vaddr, req_kind, req_priv);
        model_update();
        @(posedge clk);
        @(negedge clk);
        if (chk) compare(e, tag);
    endtask

    task automatic idle();
        req_valid = 0; wr_en = 0; inv_en = 0; rasid_we = 0; cfg_we = 0;
    endtask

    task automatic do_write(logic [2:0] w, logic [31:0] v, logic [31:0] p);
        idle(); wr_en = 1; wr_way = w; wr_vaddr = v; wr_pte = p; tick("write"); idle();
    endtask

    task automatic do_inv(logic [2:0] w, logic [31:0] v);
        idle(); inv_en = 1; inv_way = w; inv_vaddr = v; tick("inv"); idle();
    endtask

    task automatic do_rasid(logic [31:0] d);
        idle(); rasid_we = 1; rasid_wdata = d; tick("rasid"); idle();
    endtask

    task automatic do_cfg(logic [1:0] s);
        idle(); cfg_we = 1; cfg_wdata = s; tick("cfg"); idle();
    endtask

    // Directed lookup checked against literal expected values from the requirements.
    task automatic look_exp(logic [31:0] v, logic [1:0] k, logic [1:0] p, logic ok,
                            logic [5:0] c, logic [31:0] pa, logic [2:0] w, logic [1:0] r,
                            string tag);
        exp_t e;
        idle(); req_valid = 1; req_vaddr = v; req_kind = k; req_priv = p;
        model_update();
        @(posedge clk);
        @(negedge clk);
        e = '{ok: ok, cause: c, paddr: pa, way: w, ring: r};
        compare(e, tag);
        idle();
    endtask

    initial begin
        #(5.0 * 200000);
        errors++;
        $display("FAIL watchdog: expired, expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] pool [4];
        void'($urandom(32'd20240611));
        pool[0] = 32'h1230_0000; pool[1] = 32'h4560_0000;
        pool[2] = 32'h0030_0000; pool[3] = 32'hABC0_0000;
        model_reset();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (rsp_valid !== 1'b0) begin
            errors++;
            $display("FAIL R1: rsp_valid got %0d expected 0", rsp_valid);
        end

        // R1: fixed large entry maps its range to itself at ring 0
        look_exp(32'h0031_2345, 2'd0, 2'd0, 1, 0, 32'h0031_2345, 3'd4, 2'd0, "R1 fixed");
        look_exp(32'h0031_2345, 2'd2, 2'd0, 1, 0, 32'h0031_2345, 3'd4, 2'd0, "R1 fixed fetch");

        // R5 R9: small-page translation
        do_write(3'd0, 32'h1234_5000, 32'h5555_5003);
        look_exp(32'h1234_5ABC, 2'd0, 2'd0, 1, 0, 32'h5555_5ABC, 3'd0, 2'd0, "R5 R9 hit");
        look_exp(32'h1234_4ABC, 2'd0, 2'd0, 0, 24, 0, 3'd0, 2'd0, "R4 R5 data miss");
        look_exp(32'h1234_4ABC, 2'd2, 2'd0, 0, 16, 0, 3'd0, 2'd0, "R4 fetch miss");

        // R4: multi-hit, then R10 invalidate restores a single hit
        do_write(3'd1, 32'h1234_5000, 32'h6666_6003);
        look_exp(32'h1234_5ABC, 2'd0, 2'd0, 0, 25, 0, 3'd0, 2'd0, "R4 data multi");
        look_exp(32'h1234_5ABC, 2'd2, 2'd0, 0, 17, 0, 3'd0, 2'd0, "R4 fetch multi");
        do_inv(3'd1, 32'h1234_5000);
        look_exp(32'h1234_5ABC, 2'd1, 2'd0, 1, 0, 32'h5555_5ABC, 3'd0, 2'd0, "R10 inv");

        // R2 R3 R11: ring register qualification
        do_rasid(32'h0A0B_0C77);
        do_write(3'd2, 32'h2000_0000, 32'h6666_6023);
        look_exp(32'h2000_0123, 2'd0, 2'd0, 1, 0, 32'h6666_6123, 3'd2, 2'd2, "R2 R3 ring2");
        look_exp(32'h1234_5ABC, 2'd0, 2'd0, 1, 0, 32'h5555_5ABC, 3'd0, 2'd0, "R2 byte0 forced");
        // R7: privilege before rights; R11 still reports way and ring
        look_exp(32'h2000_0123, 2'd0, 2'd3, 0, 26, 0, 3'd2, 2'd2, "R7 R11 data priv");
        look_exp(32'h2000_0123, 2'd2, 2'd3, 0, 18, 0, 3'd2, 2'd2, "R7 fetch priv");
        look_exp(32'h2000_0123, 2'd2, 2'd2, 1, 0, 32'h6666_6123, 3'd2, 2'd2, "R7 equal ring");
        do_rasid(32'h0B0C_0B77);
        look_exp(32'h2000_0123, 2'd0, 2'd0, 1, 0, 32'h6666_6123, 3'd2, 2'd1, "R3 lowest byte");
        do_rasid(32'h0D0C_0E00);
        look_exp(32'h2000_0123, 2'd0, 2'd0, 0, 24, 0, 3'd0, 2'd0, "R3 absent id");
        do_rasid(32'h0403_0201);

        // R8: attribute decode and side filtering
        do_write(3'd3, 32'h3000_0000, 32'h7000_000C);
        look_exp(32'h3000_0010, 2'd0, 2'd0, 0, 28, 0, 3'd3, 2'd0, "R8 attr12 load");
        do_write(3'd3, 32'h3000_1000, 32'h7000_100D);
        look_exp(32'h3000_1010, 2'd1, 2'd0, 1, 0, 32'h7000_1010, 3'd3, 2'd0, "R8 attr13 store");
        look_exp(32'h3000_1010, 2'd2, 2'd0, 0, 20, 0, 3'd3, 2'd0, "R8 attr13 fetch");
        do_write(3'd3, 32'h3000_2000, 32'h7000_2002);
        look_exp(32'h3000_2010, 2'd3, 2'd0, 0, 20, 0, 3'd3, 2'd0, "R8 no exec");
        look_exp(32'h3000_2010, 2'd1, 2'd0, 1, 0, 32'h7000_2010, 3'd3, 2'd0, "R8 write ok");
        do_write(3'd3, 32'h3000_3000, 32'h7000_3001);
        look_exp(32'h3000_3010, 2'd1, 2'd0, 0, 29, 0, 3'd3, 2'd0, "R8 store deny");
        look_exp(32'h3000_3010, 2'd2, 2'd0, 1, 0, 32'h7000_3010, 3'd3, 2'd0, "R8 exec ok");
        do_write(3'd3, 32'h3000_3000, 32'h7000_300F);
        look_exp(32'h3000_3010, 2'd0, 2'd0, 0, 28, 0, 3'd3, 2'd0, "R8 attr15");

        // R6: large page with size field 1
        do_cfg(2'd1);
        do_write(3'd4, 32'h1340_0000, 32'h7E40_0003);
        look_exp(32'h137A_BCDE, 2'd0, 2'd0, 1, 0, 32'h7E7A_BCDE, 3'd4, 2'd0, "R6 large");
        look_exp(32'h0031_2345, 2'd0, 2'd0, 0, 24, 0, 3'd0, 2'd0, "R6 index moved");
        do_cfg(2'd0);

        // R10: fixed entry ignores write and invalidate
        do_write(3'd4, 32'h0030_0000, 32'h9990_0002);
        look_exp(32'h0031_2345, 2'd2, 2'd0, 1, 0, 32'h0031_2345, 3'd4, 2'd0, "R10 fixed write");
        do_inv(3'd4, 32'h0030_0000);
        look_exp(32'h0031_2345, 2'd0, 2'd0, 1, 0, 32'h0031_2345, 3'd4, 2'd0, "R10 fixed inv");

        // Random mix checked against the reference model (R3 R4 R7 R8 R9 R11)
        for (int it = 0; it < 6000; it++) begin
            idle();
            req_valid = ($urandom % 4) != 0;
            req_vaddr = pool[$urandom % 4] | ($urandom & 32'h000F_FFFF);
            req_kind = 2'($urandom);
            req_priv = 2'($urandom % 3);
            if ($urandom % 3 == 0) begin
                wr_en = 1; wr_way = 3'($urandom % 5);
                wr_vaddr = pool[$urandom % 4] | ($urandom & 32'h000F_F000);
                wr_pte = $urandom;
            end
            if ($urandom % 6 == 0) begin
                inv_en = 1; inv_way = 3'($urandom % 5);
                inv_vaddr = pool[$urandom % 4] | ($urandom & 32'h000F_F000);
            end
            if ($urandom % 40 == 0) begin
                rasid_we = 1;
                rasid_wdata = {8'(1 + $urandom % 5), 8'(1 + $urandom % 5),
                               8'(1 + $urandom % 5), 8'($urandom)};
            end
            if ($urandom % 60 == 0) begin
                cfg_we = 1; cfg_wdata = 2'($urandom);
            end
            tick("R4 R9 random");
        end
        idle();
        @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule